// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and the two memories on a game cartridge: a large ROM and a small battery-backed RAM. It lets the CPU reach far more storage than its address space allows by swapping banks into fixed windows. The lower 16 KiB window always shows the first ROM bank. The upper 16 KiB window shows a selectable ROM bank. An 8 KiB window at 0xA000 shows one of four RAM banks.

The ROM is read-only, so CPU writes into the ROM address range (0x0000–0x7FFF) never reach memory. Those writes load the control state instead: a RAM unlock flag, the low and high parts of the ROM bank number, the RAM bank number, and a mode flag. The mode flag decides whether the shared two-bit field feeds the ROM bank or the RAM bank. All translation and chip-select logic is combinational from the current control state. Read data from the two memories is returned to the CPU through a single mux, and a locked RAM reads as 0xFF.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A read at CPU address 0x0000–0x3FFF asserts `rom_cs` and drives `rom_addr` = {7'b0, addr[13:0]}, whatever bank is selected.
- R2: A read at 0x4000–0x7FFF asserts `rom_cs` and drives `rom_addr` = {rom_bank[6:0], addr[13:0]}, which is rom_bank×0x4000 plus the offset.
- R3: A write to 0x2000–0x3FFF loads data[4:0] into rom_bank[4:0] and keeps rom_bank[6:5]. A value of 0 in data[4:0] is stored as 1, so rom_bank[4:0] is never zero.
- R4: With the mode flag at 0 (ROM mode), a write to 0x4000–0x5FFF loads data[1:0] into rom_bank[6:5]. It keeps rom_bank[4:0] and leaves the RAM bank unchanged.
- R5: With the mode flag at 1 (RAM mode), a write to 0x4000–0x5FFF loads data[1:0] into the 2-bit RAM bank and leaves the ROM bank unchanged.
- R6: A write to 0x6000–0x7FFF loads data[0] into the mode flag (0 = ROM mode, 1 = RAM mode). The other data bits have no effect.
- R7: A write to 0x0000–0x1FFF unlocks RAM when data[3:0] equals 4'hA, whatever the upper nibble holds. Any other low nibble locks it.
- R8: `ram_cs` is asserted only for a read or write at 0xA000–0xBFFF while RAM is unlocked. `ram_addr` = {ram_bank[1:0], addr[12:0]}. `ram_we` is asserted exactly when `ram_cs` and `cpu_wr` are both high.
- R9: While RAM is locked, a read at 0xA000–0xBFFF returns 0xFF and a write there does not assert `ram_we`, so stored data is unchanged.
- R10: After synchronous reset, rom_bank = 1, ram_bank = 0, RAM is locked and ROM mode is selected.
- R11: A write at 0x8000–0xFFFF leaves all control state unchanged.
- R12: `cpu_rdata` carries `rom_rdata` for reads below 0x8000, `ram_rdata` for unlocked RAM reads, and 0xFF everywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select |
| rom_rdata | input | 8 | Data from the ROM array |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | Data from the RAM array |

## Verification
The checker enforces these rules on every cycle:
- The fixed window never carries a bank number, and a switched-window access never lands on a bank whose low five bits are zero.
- `ram_cs` stays inside its address range and is never seen while RAM is locked.
- The open-bus 0xFF value is returned on locked RAM reads.
- Writes above 0x7FFF leave the control state alone.
- In RAM mode, a shared-field write leaves the ROM bank alone.

Only the directed scenarios can show that data written to RAM comes back from the right bank, that a blocked write really left memory untouched, and that the unlock key is decided by the low nibble alone. The same holds for how a sequence of low-bank, high-bank and mode writes combines into one bank number.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    // CPU bus geometry
    localparam int CPU_AW     = 16;
    localparam int CPU_DW     = 8;

    // ROM banking geometry
    localparam int ROM_BANK_W = 7;                       // full bank number
    localparam int ROM_LO_W   = 5;                       // part loaded by the low-bank register
    localparam int ROM_HI_W   = ROM_BANK_W - ROM_LO_W;   // part shared with the RAM bank
    localparam int ROM_OFS_W  = 14;                      // 16 KiB window
    localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W;

    // RAM banking geometry
    localparam int RAM_BANK_W = 2;
    localparam int RAM_OFS_W  = 13;                      // 8 KiB window
    localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W;

    // Unlock key compared against the low nibble of the data
    localparam logic [3:0] RAM_KEY = 4'hA;

    // Value seen on the bus when nothing drives it
    localparam logic [CPU_DW-1:0] OPEN_BUS = '1;

    // Control register selected by addr[14:13] in the lower half of the map
    typedef enum logic [1:0] {
        SEL_RAM_LOCK = 2'b00,
        SEL_BANK_LO  = 2'b01,
        SEL_SHARED   = 2'b10,
        SEL_MODE     = 2'b11
    } reg_sel_e;

    // CPU address regions relevant to the cartridge
    typedef enum logic [1:0] {
        RGN_ROM_FIXED,
        RGN_ROM_SWITCH,
        RGN_RAM,
        RGN_NONE
    } region_e;

    typedef enum logic {
        MODE_ROM = 1'b0,
        MODE_RAM = 1'b1
    } bank_mode_e;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  ram_open;
        bank_mode_e            mode;
    } bank_cfg_t;

    localparam bank_cfg_t CFG_RESET = '{
        rom_bank: ROM_BANK_W'(1),
        ram_bank: '0,
        ram_open: 1'b0,
        mode:     MODE_ROM
    };

    // Region of a CPU address
    function automatic region_e addr_region(input logic [CPU_AW-1:0] a);
        region_e r;
        if (a[15:14] == 2'b00)       r = RGN_ROM_FIXED;
        else if (a[15:14] == 2'b01)  r = RGN_ROM_SWITCH;
        else if (a[15:13] == 3'b101) r = RGN_RAM;
        else                         r = RGN_NONE;
        return r;
    endfunction

    // Which control register a write into the ROM range targets
    function automatic reg_sel_e addr_reg_sel(input logic [CPU_AW-1:0] a);
        return reg_sel_e'(a[14:13]);
    endfunction

    // A zero low bank field would alias the fixed window; promote it to one
    function automatic logic [ROM_LO_W-1:0] promote_bank(input logic [ROM_LO_W-1:0] v);
        return (v == '0) ? ROM_LO_W'(1) : v;
    endfunction

    // Unlock decision: only the low nibble matters
    function automatic logic key_matches(input logic [CPU_DW-1:0] d);
        return d[3:0] == RAM_KEY;
    endfunction

endpackage

// File: rtl/cbc_decode.sv
// Address region and register-select decode for the CPU bus.
module cbc_decode
    import cart_bank_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output region_e           region,
    output reg_sel_e          sel,
    output logic              cfg_wr,     // write targets the control registers
    output logic              rom_access, // read into either ROM window
    output logic              ram_access  // read or write into the RAM window
);

    always_comb begin
        region     = addr_region(addr);
        sel        = addr_reg_sel(addr);
        cfg_wr     = wr && (region == RGN_ROM_FIXED || region == RGN_ROM_SWITCH);
        rom_access = rd && (region == RGN_ROM_FIXED || region == RGN_ROM_SWITCH);
        ram_access = (rd || wr) && (region == RGN_RAM);
    end

endmodule

// File: rtl/cbc_regs.sv
// Control register file loaded by writes into the ROM address range.
module cbc_regs
    import cart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  reg_sel_e          sel,
    input  logic [CPU_DW-1:0] wdata,
    output bank_cfg_t         cfg
);

    bank_cfg_t cfg_q;
    bank_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            unique case (sel)
                SEL_RAM_LOCK: begin
                    cfg_d.ram_open = key_matches(wdata);
                end
                SEL_BANK_LO: begin
                    cfg_d.rom_bank[ROM_LO_W-1:0] = promote_bank(wdata[ROM_LO_W-1:0]);
                end
                SEL_SHARED: begin
                    // The two-bit field goes to one destination, chosen by the mode flag
                    if (cfg_q.mode == MODE_RAM) begin
                        cfg_d.ram_bank = wdata[RAM_BANK_W-1:0];
                    end else begin
                        cfg_d.rom_bank[ROM_BANK_W-1:ROM_LO_W] = wdata[ROM_HI_W-1:0];
                    end
                end
                SEL_MODE: begin
                    cfg_d.mode = bank_mode_e'(wdata[0]);
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cbc_xlate.sv
// Physical address translation for both memories.
module cbc_xlate
    import cart_bank_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  region_e           region,
    input  bank_cfg_t         cfg,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr
);

    logic [ROM_BANK_W-1:0] rom_bank_eff;

    always_comb begin
        // The fixed window always shows bank 0
        rom_bank_eff = (region == RGN_ROM_FIXED) ? '0 : cfg.rom_bank;
        rom_addr     = {rom_bank_eff, addr[ROM_OFS_W-1:0]};
        ram_addr     = {cfg.ram_bank, addr[RAM_OFS_W-1:0]};
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
// Cartridge bank controller: control registers, translation and read mux.
module cart_bank_ctrl
    import cart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [7:0]        cpu_rdata,
    output logic [20:0]       rom_addr,
    output logic              rom_cs,
    input  logic [7:0]        rom_rdata,
    output logic [14:0]       ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata
);

    region_e   region;
    reg_sel_e  sel;
    logic      cfg_wr;
    logic      rom_access;
    logic      ram_access;
    bank_cfg_t cfg;

    cbc_decode u_decode (
        .addr       (cpu_addr),
        .wr         (cpu_wr),
        .rd         (cpu_rd),
        .region     (region),
        .sel        (sel),
        .cfg_wr     (cfg_wr),
        .rom_access (rom_access),
        .ram_access (ram_access)
    );

    cbc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .cfg_wr (cfg_wr),
        .sel    (sel),
        .wdata  (cpu_wdata),
        .cfg    (cfg)
    );

    cbc_xlate u_xlate (
        .addr     (cpu_addr),
        .region   (region),
        .cfg      (cfg),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    always_comb begin
        rom_cs = rom_access;
        ram_cs = ram_access && cfg.ram_open;
        ram_we = ram_cs && cpu_wr;

        unique case (region)
            RGN_ROM_FIXED, RGN_ROM_SWITCH: cpu_rdata = rom_rdata;
            RGN_RAM:                       cpu_rdata = cfg.ram_open ? ram_rdata : OPEN_BUS;
            default:                       cpu_rdata = OPEN_BUS;
        endcase
    end

endmodule

// File: rtl/cart_bank_chk.sv
// Cycle-level rules for the bank controller, bound onto the top module.
module cart_bank_chk
    import cart_bank_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [7:0]  cpu_rdata,
    input logic [20:0] rom_addr,
    input logic        rom_cs,
    input logic [14:0] ram_addr,
    input logic        ram_cs,
    input logic        ram_we,
    input bank_cfg_t   cfg
);

    AST_FIXED_WINDOW_BANK0: assert property (@(posedge clk) disable iff (rst)
        rom_cs && !cpu_addr[14] |-> rom_addr[20:14] == '0); // R1

    AST_ROM_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> rom_addr[13:0] == cpu_addr[13:0]); // R2

    AST_SWITCH_BANK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rom_cs && cpu_addr[14] |-> rom_addr[18:14] != '0); // R3

    AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_addr[15:13] == 3'b001 |=> cfg.rom_bank[6:5] == $past(cfg.rom_bank[6:5])); // R3

    AST_RAM_MODE_KEEPS_ROM: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_addr[15:13] == 3'b010 && cfg.mode == MODE_RAM |=> $stable(cfg.rom_bank)); // R5

    AST_RAM_CS_RANGE: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> cpu_addr[15:13] == 3'b101 && (cpu_rd || cpu_wr)); // R8

    AST_RAM_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_cs && cpu_wr); // R8

    AST_LOCKED_READ_OPEN: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && cpu_addr[15:13] == 3'b101 && !cfg.ram_open |-> cpu_rdata == 8'hFF && !ram_cs); // R9

    AST_RESET_CFG: assert property (@(posedge clk)
        rst |=> cfg == CFG_RESET); // R10

    AST_HIGH_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_addr[15] |=> $stable(cfg)); // R11

endmodule

bind cart_bank_ctrl cart_bank_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .rom_cs    (rom_cs),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cfg       (cfg)
);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wr;
    logic        cpu_rd;
    logic [7:0]  cpu_rdata;
    logic [20:0] rom_addr;
    logic        rom_cs;
    logic [7:0]  rom_rdata;
    logic [14:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [7:0]  ram_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cart_bank_ctrl i_cart_bank_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_rdata (cpu_rdata),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .rom_rdata (rom_rdata),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ram_rdata (ram_rdata)
    );

    // ROM model: contents are a function of the physical address
    function automatic logic [7:0] rom_byte(input logic [20:0] a);
        return a[7:0] ^ {1'b0, a[20:14]};
    endfunction
    assign rom_rdata = rom_byte(rom_addr);

    // RAM model: 4 banks x 256 bytes, cleared on reset
    logic [7:0] ram_mem [0:1023];
    logic [9:0] ram_idx;
    assign ram_idx   = {ram_addr[14:13], ram_addr[7:0]};
    assign ram_rdata = ram_mem[ram_idx];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) ram_mem[i] <= 8'h00;
        end else if (ram_we) begin
            ram_mem[ram_idx] <= cpu_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        cpu_rd    = 1'b0;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    // Drive a read and sample the combinational outputs mid-cycle
    task automatic bus_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        cpu_wr   = 1'b0;
        #3;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        bus_read(16'h4000);
        check(rom_addr == 21'h4000 && rom_cs, "R10 reset rom bank 1", rom_addr, 21'h4000);
        bus_read(16'hA000);
        check(cpu_rdata == 8'hFF && !ram_cs, "R10 reset ram locked", cpu_rdata, 8'hFF);
        // shared field goes to ROM upper bits after reset: ROM mode
        bus_write(16'h4000, 8'h01);
        bus_read(16'h4000);
        check(rom_addr == {7'h21, 14'h0}, "R10 reset mode rom", rom_addr, {7'h21, 14'h0});
        bus_write(16'h4000, 8'h00);
        bus_idle();
    endtask

    task automatic t_fixed_window();
        bus_write(16'h2000, 8'h07);
        bus_read(16'h1234);
        check(rom_addr == 21'h01234 && rom_cs, "R1 fixed window", rom_addr, 21'h01234);
        check(cpu_rdata == rom_byte(21'h01234), "R12 rom read data", cpu_rdata, rom_byte(21'h01234));
        bus_read(16'h3FFF);
        check(rom_addr == 21'h03FFF, "R1 fixed window top", rom_addr, 21'h03FFF);
        bus_idle();
    endtask

    task automatic t_low_bank();
        logic [20:0] e;
        bus_write(16'h2000, 8'h05);
        bus_read(16'h4123);
        e = 21'(5) * 21'h4000 + 21'h123;
        check(rom_addr == e, "R2 switched window bank 5", rom_addr, e);
        bus_write(16'h3FFF, 8'hE3);
        bus_read(16'h7FFF);
        e = {7'h03, 14'h3FFF};
        check(rom_addr == e, "R3 low five bits only", rom_addr, e);
        bus_write(16'h2000, 8'h00);
        bus_read(16'h4000);
        e = {7'h01, 14'h0};
        check(rom_addr == e, "R3 zero becomes one", rom_addr, e);
        bus_write(16'h2000, 8'h20);
        bus_read(16'h4001);
        e = {7'h01, 14'h1};
        check(rom_addr == e, "R3 zero low field with bit5 set", rom_addr, e);
        bus_idle();
    endtask

    task automatic t_upper_bits();
        logic [20:0] e;
        bus_write(16'h6000, 8'h00);
        bus_write(16'h2000, 8'h03);
        bus_write(16'h4000, 8'hFE);
        bus_read(16'h5000);
        e = {7'h43, 14'h1000};
        check(rom_addr == e, "R4 upper bits loaded", rom_addr, e);
        bus_write(16'h2000, 8'h00);
        bus_read(16'h5000);
        e = {7'h41, 14'h1000};
        check(rom_addr == e, "R3 upper bits kept", rom_addr, e);
        bus_read(16'h0010);
        check(rom_addr == 21'h10, "R1 fixed ignores upper bits", rom_addr, 21'h10);
        bus_write(16'h4000, 8'h00);
        bus_idle();
    endtask

    task automatic t_ram_unlock();
        bus_write(16'h0000, 8'h1A);
        bus_write(16'hA005, 8'h5C);
        bus_read(16'hA005);
        check(ram_cs && cpu_rdata == 8'h5C, "R7 unlock by low nibble", cpu_rdata, 8'h5C);
        check(ram_addr == 15'h0005, "R8 ram address bank 0", ram_addr, 15'h0005);
        bus_write(16'h1FFF, 8'hA0);
        bus_read(16'hA005);
        check(cpu_rdata == 8'hFF && !ram_cs, "R7 wrong nibble locks", cpu_rdata, 8'hFF);
        bus_write(16'hA005, 8'h77);
        bus_write(16'h0000, 8'h0A);
        bus_read(16'hA005);
        check(cpu_rdata == 8'h5C, "R9 locked write ignored", cpu_rdata, 8'h5C);
        bus_read(16'hC000);
        check(!ram_cs && !rom_cs && cpu_rdata == 8'hFF, "R12 unmapped reads open bus", cpu_rdata, 8'hFF);
        bus_idle();
    endtask

    task automatic t_ram_mode();
        logic [20:0] e;
        bus_write(16'h2000, 8'h04);
        bus_write(16'h6000, 8'hFF);
        bus_write(16'h4000, 8'h02);
        bus_write(16'hA010, 8'h99);
        bus_read(16'hA010);
        check(ram_addr == 15'h4010, "R5 ram bank 2 address", ram_addr, 15'h4010);
        check(cpu_rdata == 8'h99, "R8 ram bank 2 data", cpu_rdata, 8'h99);
        bus_read(16'h4000);
        e = {7'h04, 14'h0};
        check(rom_addr == e, "R5 rom bank untouched", rom_addr, e);
        bus_write(16'h4000, 8'h00);
        bus_read(16'hA010);
        check(cpu_rdata == 8'h00, "R5 other bank separate", cpu_rdata, 8'h00);
        bus_write(16'h6000, 8'hFE);
        bus_write(16'h4000, 8'h03);
        bus_read(16'h4000);
        e = {7'h64, 14'h0};
        check(rom_addr == e, "R6 mode back to rom", rom_addr, e);
        bus_read(16'hA010);
        check(ram_addr == 15'h0010, "R6 ram bank kept in rom mode", ram_addr, 15'h0010);
        bus_idle();
    endtask

    task automatic t_high_writes();
        logic [20:0] e;
        bus_write(16'h2000, 8'h09);
        bus_write(16'h4000, 8'h00);
        bus_write(16'h8000, 8'h00);
        bus_write(16'hE000, 8'h1F);
        bus_write(16'hC000, 8'h0A);
        bus_read(16'h4002);
        e = {7'h09, 14'h2};
        check(rom_addr == e, "R11 high writes no effect", rom_addr, e);
        bus_write(16'h0000, 8'h00);
        bus_write(16'h9000, 8'h0A);
        bus_read(16'hA000);
        check(cpu_rdata == 8'hFF && !ram_cs, "R11 high write does not unlock", cpu_rdata, 8'hFF);
        bus_idle();
    endtask

    initial begin
        rst       = 1'b1;
        cpu_addr  = '0;
        cpu_wdata = '0;
        cpu_wr    = 1'b0;
        cpu_rd    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_fixed_window();
        t_low_bank();
        t_upper_bits();
        t_ram_unlock();
        t_ram_mode();
        t_high_writes();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule